// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small register with parallel and serial data paths. A two-bit mode input picks one of four actions, and the action takes effect on each rising clock edge. The register can keep its contents, move every bit one place with a serial bit entering at the bottom, move every bit one place with a serial bit entering at the top, or take a whole word from the parallel input. There is one serial input for each direction. The parallel output always shows the stored word, so the bit about to be pushed out is visible there before the edge that discards it.

A typical use is serial-to-parallel and parallel-to-serial conversion. A sender loads a word and then shifts it out of its top bit. A receiver shifts that bit stream in at its bottom bit. After one shift per bit, the receiver holds the word. The data width is a parameter, with a default of 4. The mode encoding and the rule for which end each serial bit enters do not change with the width. An active-low clear empties the register at once, without waiting for a clock edge. The mode, serial and parallel pins are plain level inputs. Every edge consumes them, and there is no valid/ready handshake, so the block can never apply back-pressure.

Top module: `universal_shift_reg`

## Requirements
- R1: While `clr_n` is 0, `par_out` is all zeros within the same cycle and stays zero at every clock edge, whatever the mode.
- R2: Mode 2'b00 keeps `par_out` unchanged across a rising edge.
- R3: Mode 2'b01 moves bit i-1 into bit i at a rising edge, puts `ser_r` into bit 0, and drops the old top bit.
- R4: Mode 2'b10 moves bit i+1 into bit i at a rising edge, puts `ser_l` into bit W-1, and drops the old bit 0.
- R5: Mode 2'b11 copies `par_in` into the register at a rising edge.
- R6: Inputs the current mode does not use have no effect. These are `ser_l` and `par_in` in mode 2'b01, `ser_r` and `par_in` in mode 2'b10, both serial inputs in mode 2'b11, and every data input in mode 2'b00.
- R7: `par_out` changes only at a rising clock edge or when `clr_n` falls, and never between edges while `clr_n` is 1.
- R8: Two 8-bit instances can be chained, with the sender's bit 7 driving the receiver's `ser_r` and both in mode 2'b01. After the sender is loaded and eight edges have passed, the receiver holds the loaded word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift with `ser_r` into bit 0, 10 shift with `ser_l` into top bit, 11 parallel load |
| ser_r | input | 1 | Serial bit entering bit 0 in mode 01 |
| ser_l | input | 1 | Serial bit entering bit W-1 in mode 10 |
| par_in | input | W | Parallel load word |
| par_out | output | W | Stored word |

## Verification
The register is driven with a long pseudo-random run of modes, serial bits and parallel words. This run catches mixed-up mode codes and wrong neighbour wiring, because the two shift directions give different results on any word that is not symmetric. The run is followed by directed patterns:
- Alternating one/zero serial streams show which end each serial input enters.
- Loads of all-ones and of 0101 patterns, with the serial inputs toggling, show that each bit of the parallel word lands in the right place.
- Toggling every unused input while holding or shifting separates an honest mux select from one that leaks the wrong source.
- A clear pulse dropped between clock edges with load mode applied shows that the clear does not wait for the clock.

A chained 8-bit transfer checks the end-to-end bit order.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD     = 2'b00,
    MODE_INS_LOW  = 2'b01,
    MODE_INS_HIGH = 2'b10,
    MODE_LOAD     = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_bit_mux.sv
module usr_bit_mux
  import usr_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       keep_bit,
  input  logic       below_bit,
  input  logic       above_bit,
  input  logic       load_bit,
  output logic       next_bit
);
  // one 4:1 selector per storage bit, steered by the mode code
  always_comb begin
    unique case (usr_mode_e'(mode))
      MODE_HOLD:     next_bit = keep_bit;
      MODE_INS_LOW:  next_bit = below_bit;
      MODE_INS_HIGH: next_bit = above_bit;
      MODE_LOAD:     next_bit = load_bit;
      default:       next_bit = keep_bit;
    endcase
  end
endmodule

// File: rtl/usr_bit_reg.sv
module usr_bit_reg (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/universal_shift_reg.sv
module universal_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_r,
  input  logic         ser_l,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] par_out
);
  localparam int TOP = W - 1;

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic below_src;
    logic above_src;

    if (i == 0) begin : g_low_end
      assign below_src = ser_r;
    end else begin : g_low_mid
      assign below_src = state_q[i-1];
    end

    if (i == TOP) begin : g_high_end
      assign above_src = ser_l;
    end else begin : g_high_mid
      assign above_src = state_q[i+1];
    end

    usr_bit_mux u_mux (
      .mode      (mode),
      .keep_bit  (state_q[i]),
      .below_bit (below_src),
      .above_bit (above_src),
      .load_bit  (par_in[i]),
      .next_bit  (state_d[i])
    );

    usr_bit_reg u_reg (
      .clk   (clk),
      .clr_n (clr_n),
      .d     (state_d[i]),
      .q     (state_q[i])
    );
  end

  assign par_out = state_q;

  // R1: clear is seen at an edge as an all-zero word
  always_ff @(posedge clk) begin
    if (!clr_n) begin
      p_clear_zero_r1: assert (par_out == '0)
        else $error("R1 clear did not empty the register");
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_HOLD) |=> (par_out == $past(par_out)))
    else $error("R2 hold changed contents");

  p_ins_low_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_INS_LOW) |=> (par_out == {$past(par_out[W-2:0]), $past(ser_r)}))
    else $error("R3 low-end insertion wrong");

  p_ins_high_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_INS_HIGH) |=> (par_out == {$past(ser_l), $past(par_out[W-1:1])}))
    else $error("R4 high-end insertion wrong");

  p_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == MODE_LOAD) |=> (par_out == $past(par_in)))
    else $error("R5 load wrong");
endmodule

// File: tb/test_universal_shift_reg.sv
module test_universal_shift_reg;
  localparam int W = 4;
  localparam int CW = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         ser_r = 1'b0;
  logic         ser_l = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] par_out;

  logic [1:0]    c_mode = 2'b00;
  logic [CW-1:0] c_word = '0;
  logic [CW-1:0] tx_out;
  logic [CW-1:0] rx_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] expq = '0;

  always #4 clk = ~clk;

  universal_shift_reg #(.W(W)) i_universal_shift_reg (
    .clk(clk), .clr_n(clr_n), .mode(mode), .ser_r(ser_r), .ser_l(ser_l),
    .par_in(par_in), .par_out(par_out)
  );

  universal_shift_reg #(.W(CW)) i_tx (
    .clk(clk), .clr_n(clr_n), .mode(c_mode), .ser_r(1'b0), .ser_l(1'b0),
    .par_in(c_word), .par_out(tx_out)
  );

  universal_shift_reg #(.W(CW)) i_rx (
    .clk(clk), .clr_n(clr_n), .mode(c_mode), .ser_r(tx_out[CW-1]), .ser_l(1'b0),
    .par_in(8'h00), .par_out(rx_out)
  );

  task automatic check(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: next word from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic [1:0] m,
                                         input logic sr, input logic sl, input logic [W-1:0] pin);
    case (m)
      2'b00:   return cur;
      2'b01:   return {cur[W-2:0], sr};
      2'b10:   return {sl, cur[W-1:1]};
      default: return pin;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // called at a falling edge; applies inputs, crosses one rising edge, checks at next falling edge
  task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                      input logic [W-1:0] pin, input string req);
    mode = m; ser_r = sr; ser_l = sl; par_in = pin;
    expq = model(expq, m, sr, sl, pin);
    #2;
    check({4'h0, par_out}, {4'h0, model_prev}, "R7");
    @(posedge clk);
    @(negedge clk);
    check({4'h0, par_out}, {4'h0, expq}, req);
  endtask

  logic [W-1:0] model_prev;
  always @(negedge clk) model_prev = par_out;

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mode = 2'b11; par_in = 4'hF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({4'h0, par_out}, 8'h00, "R1 reset");
    clr_n = 1'b1;
    expq = '0;
    @(negedge clk);
    model_prev = par_out;

    // R5 load patterns, serial inputs toggling
    step(2'b11, 1'b1, 1'b1, 4'hF, "R5");
    step(2'b11, 1'b1, 1'b0, 4'h5, "R5");
    step(2'b11, 1'b0, 1'b1, 4'hA, "R5");
    // R3 alternating stream into bit 0, ser_l and par_in toggling (R6)
    for (int k = 0; k < 6; k++) step(2'b01, k[0], ~k[0], 4'hF ^ k[3:0], "R3 R6");
    // R4 stream into top bit
    step(2'b11, 1'b0, 1'b0, 4'h1, "R5");
    for (int k = 0; k < 6; k++) step(2'b10, ~k[0], k[0], 4'h0 ^ k[3:0], "R4 R6");
    // R2 hold with every data input toggling (R6)
    step(2'b11, 1'b0, 1'b0, 4'h6, "R5");
    for (int k = 0; k < 4; k++) step(2'b00, k[0], k[1], ~k[3:0], "R2 R6");
    // pseudo-random mixed run
    for (int k = 0; k < 300; k++) begin
      logic [1:0] m;
      m = 2'($urandom);
      step(m, 1'($urandom), 1'($urandom), 4'($urandom), tag_of(m));
    end

    // R1 asynchronous clear mid-cycle while load requested
    step(2'b11, 1'b0, 1'b0, 4'hF, "R5");
    mode = 2'b11; par_in = 4'hF;
    #1 clr_n = 1'b0;
    #1 check({4'h0, par_out}, 8'h00, "R1 async");
    @(posedge clk); @(negedge clk);
    check({4'h0, par_out}, 8'h00, "R1 overrides load");
    clr_n = 1'b1; expq = '0;
    step(2'b01, 1'b1, 1'b0, 4'h0, "R3");

    // R8 chained transfer
    c_word = 8'hB4; c_mode = 2'b11;
    @(posedge clk); @(negedge clk);
    check(tx_out, 8'hB4, "R8 sender load");
    c_mode = 2'b01;
    repeat (CW) @(posedge clk);
    @(negedge clk);
    check(rx_out, 8'hB4, "R8 receiver word");
    check(tx_out, 8'h00, "R8 sender emptied");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule